// File: doc/BRIEF.md
# Eight-Voice Sample Playback Sequencer

This block time-shares one register file and one incrementer among eight sample-playback voices. Each voice keeps two 16-bit words: a count of samples still to play and the address of its next sample. The sequencer visits the voices in a fixed round of slots. In each slot it runs a short, table-driven program of state cycles. The program tests the remaining count, moves that voice forward by one sample if the count is not exhausted, and sends the voice's address to the sample memory together with the voice number. A one-cycle strobe marks the point where the address and voice number can be sampled by a downstream demultiplexer.

A host starts a sound by writing a voice's location word and then its count word. Each host write is parked in a single-entry request latch and merged into the next slot's spare state cycle. While a request is still waiting, the block reports busy and ignores further writes. A voice whose count has reached zero stays on its last address, so the sample data stored there (normally silence) is repeated.

Top module: `voice_seq`

## Requirements
- R1: Slots visit voices 0,1,...,7 and then wrap to 0. `mem_chan` gives the voice whose address is on `mem_addr`.
- R2: Every slot lasts exactly 5 clock cycles. `sh_strobe` is high for exactly one cycle per slot, in the slot's last cycle.
- R3: Register index = voice*2 + `host_sel`. `host_sel`=0 selects the voice's remaining-count word and `host_sel`=1 selects its location word. A host write changes only the addressed word.
- R4: In a slot whose voice has a non-zero count, the output address is the voice's current location. The count is then decreased by 1 and the location is increased by 1, modulo 2^16, so 16'hFFFF is followed by 16'h0000.
- R5: In a slot whose voice has a count of zero, the output address is the stored location, and neither word of that voice changes.
- R6: A write presented while `host_busy` is low is accepted at that clock edge, and `host_busy` goes high in the next cycle. The write is applied in the fourth cycle of the next slot to start, after that slot's own playback update, and `host_busy` is low again in that slot's last cycle.
- R7: A write presented while `host_busy` is high is ignored and has no effect on any register.
- R8: `mem_addr` and `mem_chan` are registered and are loaded only at the end of a slot's third cycle. They hold their values in all other cycles.
- R9: While reset is asserted, `mem_addr`=0, `mem_chan`=0, `host_busy`=0 and `sh_strobe`=0, and every voice word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| host_wr | input | 1 | Host write request, sampled on a rising edge |
| host_chan | input | 3 | Voice addressed by the host write |
| host_sel | input | 1 | 0 = count word, 1 = location word |
| host_data | input | 16 | Value to write |
| host_busy | output | 1 | A host write is still pending |
| mem_addr | output | 16 | Sample memory address |
| mem_chan | output | 3 | Voice that owns `mem_addr` |
| sh_strobe | output | 1 | Sample/hold strobe, one cycle per slot |

## Verification
The hardest case to reach from the ports is a host write that lands in the same slot as the target voice's own playback update. A second case is a write that arrives while an earlier request is still pending. The bench uses the strobe as a time reference and drives each host write in the cycle before a slot starts. This fixes which slot serves the request, so a reference model can apply the write exactly after that slot's playback step. The ignored write is driven in the following cycle and targets an idle voice, so any wrong acceptance would make that voice start to advance.

// File: rtl/vs_pkg.sv
package vs_pkg;
  localparam int unsigned N_STATES = 5;

  typedef enum logic [1:0] {
    SRC_DEC  = 2'd0,
    SRC_INC  = 2'd1,
    SRC_HOST = 2'd2
  } wsrc_e;

  typedef struct packed {
    logic  use_host;
    logic  sel_loc;
    logic  reg_we;
    wsrc_e src;
    logic  cap_zero;
    logic  load_out;
    logic  clr_req;
    logic  slot_end;
  } uctl_t;
endpackage

// File: rtl/vs_ucode.sv
module vs_ucode
  import vs_pkg::*;
(
  input  logic [2:0] state,
  input  logic       req,
  input  logic       zero,
  output uctl_t      ctl
);
  // Decode table indexed by {state, req, zero}.
  always_comb begin
    ctl = '0;
    ctl.src = SRC_DEC;
    unique case (state)
      3'd0: ctl.cap_zero = 1'b1;
      3'd1: begin
        ctl.reg_we = ~zero;
        ctl.src    = SRC_DEC;
      end
      3'd2: begin
        ctl.sel_loc  = 1'b1;
        ctl.load_out = 1'b1;
        ctl.reg_we   = ~zero;
        ctl.src      = SRC_INC;
      end
      3'd3: begin
        ctl.use_host = 1'b1;
        ctl.reg_we   = req;
        ctl.src      = SRC_HOST;
        ctl.clr_req  = req;
      end
      3'd4: ctl.slot_end = 1'b1;
      default: ctl.slot_end = 1'b1;
    endcase
  end
endmodule

// File: rtl/vs_regfile.sv
module vs_regfile #(
  parameter int unsigned NUM_REGS = 16,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned RA_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RA_W-1:0]   addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [NUM_REGS];

  assign rdata = mem_q[addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) mem_q[i] <= '0;
    end else if (we) begin
      mem_q[addr] <= wdata;
    end
  end
endmodule

// File: rtl/vs_host.sv
module vs_host #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned RA_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [RA_W-1:0]   host_addr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              clr_req,
  output logic              req,
  output logic [RA_W-1:0]   tgt_addr,
  output logic [DATA_W-1:0] tgt_data
);
  logic              req_q, req_d;
  logic [RA_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    req_d  = req_q;
    addr_d = addr_q;
    data_d = data_q;
    if (clr_req) req_d = 1'b0;
    if (host_wr && !req_q) begin
      req_d  = 1'b1;
      addr_d = host_addr;
      data_d = host_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      req_q  <= req_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign req      = req_q;
  assign tgt_addr = addr_q;
  assign tgt_data = data_q;

  // R7: a write seen while busy leaves the latched request untouched
  assert_busy_ignore_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && host_wr && !clr_req) |=> ($stable(data_q) && $stable(addr_q) && req_q));

  // R6: a serviced request is cleared in the following cycle
  assert_req_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> !req_q);
endmodule

// File: rtl/voice_seq.sv
module voice_seq
  import vs_pkg::*;
#(
  parameter int unsigned NUM_VOICES = 8,
  parameter int unsigned DATA_W     = 16,
  localparam int unsigned CH_W      = $clog2(NUM_VOICES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [CH_W-1:0]   host_chan,
  input  logic              host_sel,
  input  logic [DATA_W-1:0] host_data,
  output logic              host_busy,
  output logic [DATA_W-1:0] mem_addr,
  output logic [CH_W-1:0]   mem_chan,
  output logic              sh_strobe
);
  localparam int unsigned NUM_REGS = 2 * NUM_VOICES;
  localparam int unsigned RA_W     = CH_W + 1;
  localparam logic [2:0]  ST_LAST  = 3'(N_STATES - 1);
  localparam logic [2:0]  ST_LOAD  = 3'd2;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  logic [2:0]        state_q, state_d;
  logic [CH_W-1:0]   chan_q, chan_d;
  logic              zero_q, zero_d;
  logic [DATA_W-1:0] maddr_q, maddr_d;
  logic [CH_W-1:0]   mchan_q, mchan_d;
  uctl_t             ctl;
  logic              req;
  logic [RA_W-1:0]   tgt_addr, rf_addr;
  logic [DATA_W-1:0] tgt_data, rdata, wdata;

  vs_ucode u_ucode (
    .state (state_q),
    .req   (req),
    .zero  (zero_q),
    .ctl   (ctl)
  );

  vs_host #(.DATA_W(DATA_W), .RA_W(RA_W)) u_host (
    .clk       (clk),
    .rst_n     (rst_i),
    .host_wr   (host_wr),
    .host_addr ({host_chan, host_sel}),
    .host_data (host_data),
    .clr_req   (ctl.clr_req),
    .req       (req),
    .tgt_addr  (tgt_addr),
    .tgt_data  (tgt_data)
  );

  // Two-way address select: playback voice or host-latched target
  assign rf_addr = ctl.use_host ? tgt_addr : {chan_q, ctl.sel_loc};

  always_comb begin
    unique case (ctl.src)
      SRC_DEC:  wdata = rdata - 1'b1;
      SRC_INC:  wdata = rdata + 1'b1;
      default:  wdata = tgt_data;
    endcase
  end

  vs_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk   (clk),
    .rst_n (rst_i),
    .addr  (rf_addr),
    .we    (ctl.reg_we),
    .wdata (wdata),
    .rdata (rdata)
  );

  always_comb begin
    state_d = ctl.slot_end ? 3'd0 : state_q + 3'd1;
    chan_d  = ctl.slot_end ? chan_q + 1'b1 : chan_q;
    zero_d  = ctl.cap_zero ? (rdata == '0) : zero_q;
    maddr_d = ctl.load_out ? rdata  : maddr_q;
    mchan_d = ctl.load_out ? chan_q : mchan_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      state_q <= 3'd0;
      chan_q  <= '0;
      zero_q  <= 1'b1;
      maddr_q <= '0;
      mchan_q <= '0;
    end else begin
      state_q <= state_d;
      chan_q  <= chan_d;
      zero_q  <= zero_d;
      maddr_q <= maddr_d;
      mchan_q <= mchan_d;
    end
  end

  assign mem_addr  = maddr_q;
  assign mem_chan  = mchan_q;
  assign sh_strobe = (state_q == ST_LAST);
  assign host_busy = req;

  // R1: voices are taken in ascending order with wrap
  assert_slot_order_R1: assert property (@(posedge clk) disable iff (!rst_i)
    ctl.slot_end |=> (chan_q == $past(chan_q) + 1'b1));

  // R2: state cycles step by one until the last one of the slot
  assert_slot_len_R2: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_LAST) |=> (state_q == $past(state_q) + 3'd1));

  // R5: a count word is never decremented from zero
  assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (ctl.reg_we && ctl.src == SRC_DEC) |-> (rdata != '0));

  // R8: outputs change only at the end of the load cycle
  assert_out_hold_R8: assert property (@(posedge clk) disable iff (!rst_i)
    (state_q != ST_LOAD) |=> ($stable(maddr_q) && $stable(mchan_q)));
endmodule

// File: tb/voice_seq_tb.sv
`timescale 1ns/1ps
module voice_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_wr;
  logic [2:0]  host_chan;
  logic        host_sel;
  logic [15:0] host_data;
  logic        host_busy;
  logic [15:0] mem_addr;
  logic [2:0]  mem_chan;
  logic        sh_strobe;

  int checks = 0;
  int errors = 0;

  logic [15:0] mdl [16];
  int          exp_chan = 0;
  bit          pend_v = 0;
  int          pend_i = 0;
  logic [15:0] pend_d = '0;

  always #2 clk = ~clk;

  voice_seq u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_chan(host_chan),
    .host_sel(host_sel), .host_data(host_data), .host_busy(host_busy),
    .mem_addr(mem_addr), .mem_chan(mem_chan), .sh_strobe(sh_strobe)
  );

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", r, act, exp, $time);
    end
  endtask

  task automatic wait_strobe();
    do @(negedge clk); while (sh_strobe !== 1'b1);
  endtask

  // One slot: compare outputs with model, then advance model
  task automatic slot_step(input string r);
    int c;
    wait_strobe();
    c = exp_chan;
    chk(r, 32'(mem_chan), 32'(c));
    chk(r, 32'(mem_addr), 32'(mdl[2*c+1]));
    if (mdl[2*c] != 16'd0) begin
      mdl[2*c]   = mdl[2*c] - 16'd1;
      mdl[2*c+1] = mdl[2*c+1] + 16'd1;
    end
    exp_chan = (exp_chan + 1) % 8;
    if (pend_v) begin
      mdl[pend_i] = pend_d;
      pend_v = 0;
    end
  endtask

  task automatic run_slots(input int n, input string r);
    for (int i = 0; i < n; i++) slot_step(r);
  endtask

  // Called at a strobe cycle: write lands in next slot
  task automatic host_write(input int ch, input bit sel, input logic [15:0] d);
    host_chan = 3'(ch); host_sel = sel; host_data = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R6 busy after accept", 32'(host_busy), 32'd1);
    pend_v = 1; pend_i = ch*2 + int'(sel); pend_d = d;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; host_wr = 1'b0; host_chan = '0; host_sel = 1'b0; host_data = '0;
    repeat (3) @(negedge clk);
    chk("R9 mem_addr", 32'(mem_addr), 32'd0);
    chk("R9 mem_chan", 32'(mem_chan), 32'd0);
    chk("R9 busy", 32'(host_busy), 32'd0);
    chk("R9 strobe", 32'(sh_strobe), 32'd0);
    rst_n = 1'b1;
    run_slots(8, "R9 voices idle at 0");
  endtask

  task automatic t_strobe_period();
    int gap;
    wait_strobe();
    exp_chan = (exp_chan + 1) % 8;
    gap = 0;
    do begin @(negedge clk); gap++; end while (sh_strobe !== 1'b1);
    chk("R2 slot length", 32'(gap), 32'd5);
    exp_chan = (exp_chan + 1) % 8;
  endtask

  task automatic t_play();
    slot_step("R1");
    host_write(2, 1'b0, 16'd3);
    slot_step("R3");
    host_write(2, 1'b1, 16'h1000);
    slot_step("R3");
    run_slots(32, "R4 play");
    run_slots(16, "R5 frozen");
  endtask

  task automatic t_busy();
    slot_step("R6");
    host_chan = 3'd5; host_sel = 1'b1; host_data = 16'h2222; host_wr = 1'b1;
    @(negedge clk);
    chk("R6 busy", 32'(host_busy), 32'd1);
    pend_v = 1; pend_i = 11; pend_d = 16'h2222;
    host_chan = 3'd6; host_sel = 1'b0; host_data = 16'h9999;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R7 still busy", 32'(host_busy), 32'd1);
    slot_step("R6");
    chk("R6 busy cleared", 32'(host_busy), 32'd0);
    host_write(5, 1'b0, 16'd1);
    slot_step("R6");
    run_slots(24, "R7 ignored write");
  endtask

  task automatic t_wrap();
    slot_step("R4");
    host_write(7, 1'b1, 16'hFFFF);
    slot_step("R4");
    host_write(7, 1'b0, 16'd2);
    slot_step("R4");
    run_slots(24, "R4 wrap");
  endtask

  task automatic t_hold();
    logic [15:0] a;
    logic [2:0]  c;
    slot_step("R8");
    a = mem_addr; c = mem_chan;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R8 addr hold", 32'(mem_addr), 32'(a));
      chk("R8 chan hold", 32'(mem_chan), 32'(c));
    end
    run_slots(9, "R8");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mdl[i] = '0;
    t_reset();
    t_strobe_period();
    t_play();
    t_busy();
    t_wrap();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule